// File: doc/BRIEF.md
# Sample-Rate Timing NCO with Sample Clock

This block paces the uptake of baseband samples by a shaping filter. A 30-bit phase accumulator advances by a programmable frequency word on every reference clock edge. Its top bit is brought out as a sample clock with close to even high and low times, so an external data source can follow the filter's sample rate. Each time that top bit falls, the block raises a one-cycle strobe. The strobe tells the filter to take the next word from its input FIFO.

After reset the accumulator stays parked at zero and nothing advances. Processing starts on a sync event. A sync event is either a command pulse on the control side or an edge on an external sync pin. A polarity select chooses whether a rising or a falling edge on that pin counts. Every accepted sync event clears the phase. The event is also echoed on a one-cycle sync output, so several units can be wired to one master and start in step.

Top module: `samp_timing_nco`

## Requirements
- R1: A high `rst` sampled at a clock edge clears the phase, the frequency word and all outputs to 0, and halts the block. While halted, `samp_clk`, `samp_stb` and `sync_out` stay 0 whatever frequency word is loaded, until a sync event.
- R2: A high `cfg_we` at an edge loads `cfg_freq` into the frequency word. The new word is first added at the following edge.
- R3: While running, the phase grows by the frequency word at each edge, modulo 2^30.
- R4: `samp_clk` equals bit 29, the most significant bit, of the phase register.
- R5: `samp_stb` is high for exactly the one cycle after an accumulation step moves the phase MSB from 1 to 0. This is the first low cycle of `samp_clk`. A clear caused by a sync event gives no strobe.
- R6: A high `cmd_sync` at an edge sets the phase to 0 and starts processing at that edge. The phase is F after one more edge, where F is the frequency word.
- R7: `sync_in` passes through two synchronizing flops. An accepted edge clears the phase and starts processing at the third rising clock edge, counting the first edge that samples the new level. With `sync_pol`=0 a 0-to-1 change is accepted; with `sync_pol`=1 a 1-to-0 change is accepted.
- R8: A `sync_in` change of the polarity not selected has no effect on phase, run state or `sync_out`.
- R9: `sync_out` is a one-cycle high pulse in the cycle after each accepted sync event. In that cycle the phase is 0.
- R10: A sync event while running re-clears the phase to 0. Accumulation then restarts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; halts processing |
| cfg_we | input | 1 | Load strobe for the frequency word |
| cfg_freq | input | 30 | Frequency word (phase increment per clock) |
| cmd_sync | input | 1 | Control-side sync command pulse |
| sync_pol | input | 1 | External sync edge select: 0 rising, 1 falling |
| sync_in | input | 1 | External sync pin, asynchronous |
| samp_clk | output | 1 | Sample clock, phase MSB |
| samp_stb | output | 1 | One-cycle sample-take strobe |
| sync_out | output | 1 | One-cycle echo of each accepted sync event |

## Verification
The outputs follow their causes with fixed delays:
- `samp_clk` and `samp_stb` reflect the accumulation step of the edge just passed.
- `sync_out` and the cleared phase appear one edge after a `cmd_sync`.
- They appear three edges after a `sync_in` change, counting the edge that samples the change.
- A new frequency word shows up in `samp_clk` two edges after `cfg_we`.

The bench drives inputs 1 ns after a rising edge. It advances its own reference model once per edge and compares all three outputs right after every edge. The synchronizer delay, the halt state and the timing of frequency updates are therefore checked on every cycle.

// File: rtl/samp_nco_pkg.sv
package samp_nco_pkg;

    localparam int unsigned PHASE_W_DEF = 30;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } sync_edge_e;

    typedef struct packed {
        logic clear;
        logic start;
    } sync_req_t;

    function automatic logic msb_dropped(input logic old_msb, input logic new_msb);
        return old_msb & ~new_msb;
    endfunction

    function automatic logic edge_match(input sync_edge_e pol, input logic cur, input logic prev);
        return (pol == EDGE_RISE) ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det
    import samp_nco_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_in,
    input  sync_edge_e pol,
    output logic       edge_o
);

    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] chain_q;

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= sig_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign edge_o = edge_match(pol, chain_q[LEN-2], chain_q[LEN-1]);

endmodule

// File: rtl/phase_accum.sv
module phase_accum
    import samp_nco_pkg::*;
#(
    parameter int unsigned W = PHASE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         clear,
    input  logic [W-1:0] incr,
    output logic [W-1:0] phase_o,
    output logic         wrap_o
);

    logic [W-1:0] phase_q;
    logic [W-1:0] sum;
    logic         wrap_q;

    assign sum = phase_q + incr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            wrap_q  <= 1'b0;
        end else if (clear) begin
            phase_q <= '0;
            wrap_q  <= 1'b0;
        end else if (run_en) begin
            phase_q <= sum;
            wrap_q  <= msb_dropped(phase_q[W-1], sum[W-1]);
        end else begin
            wrap_q  <= 1'b0;
        end
    end

    assign phase_o = phase_q;
    assign wrap_o  = wrap_q;

endmodule

// File: rtl/samp_timing_nco.sv
module samp_timing_nco
    import samp_nco_pkg::*;
#(
    parameter int unsigned ACC_W       = PHASE_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [ACC_W-1:0] cfg_freq,
    input  logic             cmd_sync,
    input  logic             sync_pol,
    input  logic             sync_in,
    output logic             samp_clk,
    output logic             samp_stb,
    output logic             sync_out
);

    localparam int unsigned MSB = ACC_W - 1;

    logic [ACC_W-1:0] freq_q;
    logic [ACC_W-1:0] acc;
    logic             halted;
    logic             ext_edge;
    logic             sync_ev;
    logic             sync_out_q;
    sync_req_t        req;

    sync_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (sync_in),
        .pol    (sync_edge_e'(sync_pol)),
        .edge_o (ext_edge)
    );

    assign sync_ev   = cmd_sync | ext_edge;
    assign req.clear = sync_ev;
    assign req.start = sync_ev & halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_q     <= '0;
            halted     <= 1'b1;
            sync_out_q <= 1'b0;
        end else begin
            if (cfg_we)    freq_q <= cfg_freq;
            if (req.start) halted <= 1'b0;
            sync_out_q <= req.clear;
        end
    end

    phase_accum #(.W(ACC_W)) i_acc (
        .clk     (clk),
        .rst     (rst),
        .run_en  (~halted),
        .clear   (req.clear),
        .incr    (freq_q),
        .phase_o (acc),
        .wrap_o  (samp_stb)
    );

    assign samp_clk = acc[MSB];
    assign sync_out = sync_out_q;

endmodule

// File: rtl/samp_timing_nco_chk.sv
module samp_timing_nco_chk #(
    parameter int unsigned W = 30
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_sync,
    input logic         samp_clk,
    input logic         samp_stb,
    input logic         sync_out,
    input logic         halted,
    input logic         sync_ev,
    input logic [W-1:0] acc,
    input logic [W-1:0] freq
);

    // R5
    stb_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        samp_stb |-> (!samp_clk && $past(samp_clk)));

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        samp_stb |=> !samp_stb);

    // R9
    sync_zero_phase_chk: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> (acc == '0 && !samp_stb));

    // R6
    cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_sync |=> (sync_out && !halted));

    // R1
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !sync_ev) |=> (halted && acc == '0 && !samp_stb));

    // R3
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && !sync_ev) |=> (acc == W'($past(acc) + $past(freq))));

endmodule

bind samp_timing_nco samp_timing_nco_chk #(.W(ACC_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_sync (cmd_sync),
    .samp_clk (samp_clk),
    .samp_stb (samp_stb),
    .sync_out (sync_out),
    .halted   (halted),
    .sync_ev  (sync_ev),
    .acc      (acc),
    .freq     (freq_q)
);

// File: tb/test_samp_timing_nco.sv
module test_samp_timing_nco;

    localparam int W = 30;
    localparam logic [W-1:0] HALF = 30'h2000_0000;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_we;
    logic [W-1:0] cfg_freq;
    logic         cmd_sync;
    logic         sync_pol;
    logic         sync_in;
    logic         samp_clk;
    logic         samp_stb;
    logic         sync_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [W-1:0] m_acc, m_freq;
    logic         m_run, m_stb, m_sout;
    logic [2:0]   m_hist;   // [0] newest sample of sync_in

    always #2 clk = ~clk;

    samp_timing_nco i_samp_timing_nco (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_freq(cfg_freq),
        .cmd_sync(cmd_sync), .sync_pol(sync_pol), .sync_in(sync_in),
        .samp_clk(samp_clk), .samp_stb(samp_stb), .sync_out(sync_out)
    );

    function automatic logic ext_accept(input logic pol, input logic cur, input logic prev);
        return pol ? (!cur && prev) : (cur && !prev);
    endfunction

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s=%0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(input string tag);
        logic         ev;
        logic [W-1:0] sum;
        ev  = cmd_sync | ext_accept(sync_pol, m_hist[1], m_hist[2]);
        sum = m_acc + m_freq;
        if (rst) begin
            m_acc = '0; m_freq = '0; m_run = 1'b0; m_stb = 1'b0; m_sout = 1'b0; m_hist = '0;
        end else begin
            m_stb  = m_run && !ev && m_acc[W-1] && !sum[W-1];
            m_acc  = ev ? '0 : (m_run ? sum : m_acc);
            m_run  = m_run | ev;
            if (cfg_we) m_freq = cfg_freq;
            m_sout = ev;
            m_hist = {m_hist[1:0], sync_in};
        end
        @(posedge clk);
        #1;
        check1(tag, "samp_clk", samp_clk, m_acc[W-1]);
        check1(tag, "samp_stb", samp_stb, m_stb);
        check1(tag, "sync_out", sync_out, m_sout);
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic load(input logic [W-1:0] f, input string tag);
        cfg_freq = f; cfg_we = 1'b1;
        tick(tag);
        cfg_we = 1'b0;
    endtask

    task automatic cmd(input string tag);
        cmd_sync = 1'b1;
        tick(tag);
        cmd_sync = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1'b1; cfg_we = 1'b0; cfg_freq = '0; cmd_sync = 1'b0; sync_pol = 1'b0; sync_in = 1'b0;
        m_acc = '0; m_freq = '0; m_run = 1'b0; m_stb = 1'b0; m_sout = 1'b0; m_hist = '0;
        run("R1", 3);
        rst = 1'b0;
        run("R1", 2);

        // halted: a loaded word must not move anything (R1)
        load(HALF + 30'd12345, "R2");
        run("R1", 12);

        // wrong-polarity edge ignored (R8), correct one starts (R7, R9)
        sync_pol = 1'b1;
        sync_in  = 1'b1;
        run("R8", 6);
        sync_in  = 1'b0;
        run("R7", 3);
        run("R9", 2);
        run("R4", 40);
        run("R5", 40);

        // resync while running (R6, R10)
        cmd("R6");
        run("R10", 30);

        // exact half rate: clock toggles every cycle (R5)
        load(HALF, "R2");
        run("R5", 20);
        // zero word freezes the phase (R3)
        load('0, "R3");
        run("R3", 10);
        // largest word: phase steps back by one each cycle (R3)
        load({W{1'b1}}, "R3");
        run("R3", 20);
        // word change mid-run, first used one edge later (R2)
        load(30'h0123_4567, "R2");
        run("R2", 30);

        // rising polarity while running (R7, R10)
        sync_pol = 1'b0;
        sync_in  = 1'b1;
        run("R7", 8);
        sync_pol = 1'b0;
        sync_in  = 1'b0;
        run("R8", 8);

        // constrained random segments
        for (int s = 0; s < 40; s++) begin
            load(($urandom() % 4 == 0) ? ($urandom() & 30'h00FF_FFFF) : W'($urandom()), "R2");
            for (int c = 0; c < 150; c++) begin
                int r;
                r = $urandom() % 64;
                if (r == 0) cmd_sync = 1'b1;
                if (r == 1) sync_in = ~sync_in;
                if (r == 2) sync_pol = ~sync_pol;
                tick("R3");
                cmd_sync = 1'b0;
            end
        end

        // reset mid-run returns to halt (R1)
        rst = 1'b1;
        run("R1", 2);
        rst = 1'b0;
        sync_in = 1'b0;
        load(HALF + 30'd1, "R1");
        run("R1", 10);
        cmd("R6");
        run("R5", 30);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule